// File: doc/BRIEF.md
# Streaming Matrix-Vector Multiplier

This block forms y = A·x for an m-by-n matrix of signed coefficients held in an on-block store. The vector x streams in one element per accepted beat. Each arriving element x_j is multiplied at once by every entry of column j, and the m products are added into m running sums. Work therefore overlaps the arrival of the vector, and no element of x is kept. In a receiver it serves as a least-squares channel estimator: the pseudo-inverse of the training matrix sits in the coefficient store and the received training samples are streamed through it.

The input is a valid/ready stream. A beat is taken on any rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only while a coefficient write is in progress (`cf_we` high). A producer may hold `in_valid` and its data across such a stall, and the beat is taken on the first cycle the write ends. Nothing else applies back-pressure, so vectors may follow one another with no idle cycle between them. The coefficient port is a plain write strobe with row and column addresses. The m saturated results come out in parallel and are marked by a one-cycle `done_o` pulse.

Top module: `smv_mul`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every result lane reads 0 and `done_o` is 0. `in_ready` is low while `rst` is high. Every coefficient is 0 after reset.
- R2: Accepted beats are numbered 0..COLS-1 in arrival order, and beat j uses column j. After the beat numbered COLS-1, lane i of `y_o` (bits i*OW upward) holds the saturated value of the sum over j of A[i][j]·x_j. Inputs and coefficients are signed two's complement, and the sums are carried without internal overflow.
- R3: `done_o` is high for exactly one cycle: the cycle after the clock edge that accepts a vector's final beat. `y_o` takes the new results in that same cycle.
- R4: `y_o` stays unchanged in every cycle where `done_o` is low.
- R5: A beat accepted on the edge right after a vector's final beat starts a new vector. Its product replaces the old sums, so back-to-back vectors need no gap.
- R6: A beat accepted with `in_first` high is treated as element 0, whatever count was reached. The partial sums gathered before it are discarded.
- R7: Each result is clamped to the signed OW-bit range: sums above 2^(OW-1)-1 give 2^(OW-1)-1, and sums below -2^(OW-1) give -2^(OW-1).
- R8: A cycle with `cf_we` high writes `cf_data` into A[`cf_row`][`cf_col`] at the clock edge. Beats accepted from the next cycle onward use the new value.
- R9: While `cf_we` is high, `in_ready` is low. A beat presented in that cycle is not taken: it changes neither the sums nor the element count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block can take an element this cycle |
| in_first | input | 1 | Element is the first of a vector |
| in_data | input | DW | Signed input element |
| cf_we | input | 1 | Coefficient write strobe |
| cf_row | input | $clog2(ROWS) | Coefficient row address |
| cf_col | input | $clog2(COLS) | Coefficient column address |
| cf_data | input | CW | Signed coefficient value |
| y_o | output | ROWS*OW | Results, lane i in bits i*OW+OW-1 : i*OW |
| done_o | output | 1 | One-cycle pulse when new results appear |

## Verification
The hardest case to reach from the ports is a coefficient write that lands in the middle of a vector while the producer holds a beat valid. The stall has to leave the element count and the partial sums alone, and the new coefficient has to apply only to columns not yet consumed. The stimulus reaches it by keeping `in_valid` high through a stretch of random coefficient writes interleaved with beats. A behavioural reference checks every cycle. Further runs force a restart in mid-vector, stream vectors back-to-back, and use large operands of both signs so that both saturation bounds are hit.

// File: rtl/smv_pkg.sv
package smv_pkg;
  // Width of a lane accumulator: full product plus guard bits for COLS terms.
  function automatic int acc_width(input int dw, input int cw, input int cols);
    return dw + cw + $clog2(cols);
  endfunction
endpackage

// File: rtl/smv_coef_store.sv
module smv_coef_store #(
  parameter int ROWS = 6,
  parameter int COLS = 5,
  parameter int CW   = 16,
  localparam int RW  = $clog2(ROWS),
  localparam int CIW = $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [RW-1:0]      wr_row,
  input  logic [CIW-1:0]     wr_col,
  input  logic [CW-1:0]      wr_data,
  input  logic [CIW-1:0]     rd_col,
  output logic [ROWS*CW-1:0] col_vec
);
  logic [CW-1:0] mem [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (rst) mem[r][c] <= '0;
        else if (we && wr_row == RW'(r) && wr_col == CIW'(c)) mem[r][c] <= wr_data;
      end
    end
    assign col_vec[r*CW +: CW] = mem[r][rd_col];
  end

  assert_wr_addr_R8: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(wr_row) < ROWS && int'(wr_col) < COLS));
endmodule

// File: rtl/smv_seq.sv
module smv_seq #(
  parameter int COLS = 5,
  localparam int CIW = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_first,
  input  logic           cf_we,
  output logic           in_ready,
  output logic           beat,
  output logic [CIW-1:0] col_idx,
  output logic           first,
  output logic           last,
  output logic           done
);
  logic [CIW-1:0] cnt;

  assign in_ready = !rst && !cf_we;
  assign beat     = in_valid && in_ready;
  assign col_idx  = in_first ? '0 : cnt;
  assign first    = (col_idx == '0);
  assign last     = (col_idx == CIW'(COLS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= beat && last;
      if (beat) cnt <= last ? '0 : col_idx + 1'b1;
    end
  end

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < COLS);
  assert_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (cf_we && in_valid) |=> $stable(cnt));
  assert_done_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt == '0);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/smv_lane.sv
module smv_lane #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 35,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat,
  input  logic                 first,
  input  logic                 last,
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] coef,
  output logic signed [OW-1:0] y
);
  logic signed [DW+CW-1:0] prod;
  logic signed [AW-1:0]    prod_ext, acc, sum;
  logic signed [OW-1:0]    clamped;

  assign prod     = x * coef;
  assign prod_ext = AW'(prod);
  assign sum      = (first ? '0 : acc) + prod_ext;

  if (OW >= AW) begin : g_wide
    assign clamped = OW'(sum);
  end else begin : g_sat
    localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = ~MAXV;
    always_comb begin
      if (sum > MAXV)      clamped = MAXV[OW-1:0];
      else if (sum < MINV) clamped = MINV[OW-1:0];
      else                 clamped = sum[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      y   <= '0;
    end else if (beat) begin
      acc <= sum;
      if (last) y <= clamped;
    end
  end
endmodule

// File: rtl/smv_mul.sv
module smv_mul #(
  parameter int ROWS = 6,
  parameter int COLS = 5,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int OW   = 24,
  localparam int RW  = $clog2(ROWS),
  localparam int CIW = $clog2(COLS),
  localparam int AW  = smv_pkg::acc_width(DW, CW, COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_first,
  input  logic [DW-1:0]      in_data,
  input  logic               cf_we,
  input  logic [RW-1:0]      cf_row,
  input  logic [CIW-1:0]     cf_col,
  input  logic [CW-1:0]      cf_data,
  output logic [ROWS*OW-1:0] y_o,
  output logic               done_o
);
  logic               beat, first, last;
  logic [CIW-1:0]     col_idx;
  logic [ROWS*CW-1:0] col_vec;

  smv_seq #(.COLS(COLS)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .cf_we(cf_we), .in_ready(in_ready), .beat(beat), .col_idx(col_idx),
    .first(first), .last(last), .done(done_o)
  );

  smv_coef_store #(.ROWS(ROWS), .COLS(COLS), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .we(cf_we), .wr_row(cf_row), .wr_col(cf_col),
    .wr_data(cf_data), .rd_col(col_idx), .col_vec(col_vec)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_lane
    smv_lane #(.DW(DW), .CW(CW), .AW(AW), .OW(OW)) u_lane (
      .clk(clk), .rst(rst), .beat(beat), .first(first), .last(last),
      .x(in_data), .coef(col_vec[r*CW +: CW]), .y(y_o[r*OW +: OW])
    );
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(y_o));
endmodule

// File: tb/smv_mul_bench.sv
`timescale 1ns/1ps
module smv_mul_bench;
  localparam int ROWS = 6, COLS = 5, DW = 16, CW = 16, OW = 24;
  localparam int RW = $clog2(ROWS), CIW = $clog2(COLS);
  localparam longint MAXO = (64'sd1 <<< (OW-1)) - 1;
  localparam longint MINO = -(64'sd1 <<< (OW-1));

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_first = 0, cf_we = 0;
  logic [DW-1:0] in_data = '0;
  logic [RW-1:0] cf_row = '0;
  logic [CIW-1:0] cf_col = '0;
  logic [CW-1:0] cf_data = '0;
  logic in_ready, done_o;
  logic [ROWS*OW-1:0] y_o;

  always #10 clk = ~clk;

  smv_mul u_smv_mul (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_data(in_data), .cf_we(cf_we), .cf_row(cf_row),
    .cf_col(cf_col), .cf_data(cf_data), .y_o(y_o), .done_o(done_o));

  int tests = 0, fails = 0;
  string tag = "R1";
  bit finished = 0;

  longint a_m [ROWS][COLS];
  longint psum [ROWS];
  longint exp_y [ROWS];
  bit exp_done = 0;
  int idx = 0;

  function automatic longint clampv(longint v);
    if (v > MAXO) return MAXO;
    if (v < MINO) return MINO;
    return v;
  endfunction

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) begin
        psum[i] = 0; exp_y[i] = 0;
        for (int j = 0; j < COLS; j++) a_m[i][j] = 0;
      end
      exp_done = 0; idx = 0;
    end else begin
      exp_done = 0;
      if (in_valid && !cf_we) begin
        int j;
        j = in_first ? 0 : idx;
        for (int i = 0; i < ROWS; i++) begin
          psum[i] = (j == 0 ? 0 : psum[i]) + a_m[i][j] * longint'($signed(in_data));
          if (j == COLS-1) exp_y[i] = clampv(psum[i]);
        end
        if (j == COLS-1) begin exp_done = 1; idx = 0; end
        else idx = j + 1;
      end
      if (cf_we) a_m[cf_row][cf_col] = longint'($signed(cf_data));
    end
  end

  task automatic chk(string what, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("done_o", longint'(done_o), longint'(exp_done));
    chk("in_ready", longint'(in_ready), longint'(!rst && !cf_we));
    for (int i = 0; i < ROWS; i++)
      chk($sformatf("y[%0d]", i), longint'($signed(y_o[i*OW +: OW])), exp_y[i]);
  endtask

  task automatic idle(int n);
    in_valid = 0; in_first = 0; cf_we = 0;
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic wr(int r, int c, int v);
    cf_we = 1; cf_row = RW'(r); cf_col = CIW'(c); cf_data = CW'(v);
    cyc();
    cf_we = 0;
  endtask

  task automatic beat(int v, bit f);
    in_valid = 1; in_first = f; in_data = DW'(v);
    cyc();
    in_valid = 0; in_first = 0;
  endtask

  task automatic load_all(int lim);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        wr(r, c, $urandom_range(0, 2*lim) - lim);
  endtask

  task automatic vec(int lim, int gap);
    for (int j = 0; j < COLS; j++) begin
      beat($urandom_range(0, 2*lim) - lim, j == 0);
      if (gap > 0) idle(gap);
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    for (int k = 0; k < 3; k++) cyc();
    rst = 0;
    cyc();
    // R8: load coefficients and use them
    tag = "R8";
    load_all(300);
    vec(200, 1);
    idle(2);
    // R2: several vectors with varied gaps and signs
    tag = "R2";
    for (int v = 0; v < 4; v++) vec(1000, v % 2);
    idle(2);
    // R5: back-to-back vectors, no idle cycle
    tag = "R5";
    for (int v = 0; v < 4; v++) vec(500, 0);
    // R4: results held while idle
    tag = "R4";
    idle(6);
    // R6: restart mid-vector
    tag = "R6";
    beat(77, 1); beat(-55, 0); beat(33, 0);
    vec(400, 0);
    idle(2);
    // R9: writes interleaved with a held-valid stream
    tag = "R9";
    for (int k = 0; k < 40; k++) begin
      in_valid = 1;
      in_first = 0;
      in_data = DW'($urandom_range(0, 600) - 300);
      if ($urandom_range(0, 2) == 0) begin
        cf_we = 1; cf_row = RW'($urandom_range(0, ROWS-1));
        cf_col = CIW'($urandom_range(0, COLS-1));
        cf_data = CW'($urandom_range(0, 600) - 300);
      end else cf_we = 0;
      cyc();
    end
    idle(3);
    // R8: single coefficient change takes effect on the next vector
    tag = "R8";
    wr(2, 3, 12345);
    vec(300, 0);
    idle(2);
    // R7: saturation, both bounds
    tag = "R7";
    load_all(32767);
    for (int v = 0; v < 6; v++) vec(32767, 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wr(r, c, (r % 2) ? -32768 : 32767);
    for (int j = 0; j < COLS; j++) beat(32767, j == 0);
    for (int j = 0; j < COLS; j++) beat(-32768, j == 0);
    idle(3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired during %s", tag);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule